// File: doc/BRIEF.md
# Bus Handover Arbiter

The block lets up to two outside bus masters borrow the local bus from the processor. Each master shares one open-drain, pulled-up line with the block. A handover uses exactly three one-clock, active-low pulses on that line. First the master pulses to ask for the bus. Then the block pulses back on the same line to grant it. Finally the master pulses again when it gives the bus back.

The block learns where the processor's own bus cycle stands through a phase input from the bus sequencer. It grants only where the running cycle allows it. From the clock after the grant it raises a float output, which tells the bus drivers to release the bus.

A lock input stops new grants while a locked instruction needs the bus. When both lines ask at once, line 0 wins. A request that cannot be served at once is remembered and served later. After every release the processor keeps the bus for at least one dead clock before the next grant.

Top module: `bus_handover_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_drv_o` is all zero and `float_o` is 0.
- R2: A request is a line read low for one clock while the block is not driving it. A request sampled with the bus at home, with `lock_i` low and with `phase_i` at 0 (no bus cycle), 1 (T1) or 4 (T4) makes the block drive that line low in the very next clock. This grant pulse lasts exactly one clock.
- R3: With `phase_i` at 2 (T2), 3 (T3) or 5 (wait state), no grant is issued. The request is held and is granted in the clock after the first sampling edge at which the phase is 0, 1 or 4.
- R4: `float_o` rises in the clock after a grant pulse and stays high until a release is seen.
- R5: While `float_o` is high, a low pulse on the owning master's line is a release. `float_o` falls in the next clock.
- R6: In the clock after `float_o` falls, no line is driven. A held request is granted in the clock after that at the earliest.
- R7: When lines 0 and 1 request in the same clock, line 0 is granted and line 1 is held. Line 1 is granted after line 0's exchange and the dead clock.
- R8: No grant pulse follows a sampling edge at which `lock_i` is high. A request seen during lock is kept and is granted once lock drops.
- R9: A line that stays high, such as an unconnected line, never causes a grant or a float.
- R10: At most one line is driven at any time, and the block drives a line only during its grant clock.
- R11: A request on the other line while one master owns the bus is held, not granted. It is served right after the owner's release and the dead clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Sampled level of each request/grant line (1 = idle) |
| line_drv_o | output | NUM_LINES | Pull-low enable for each line (1 = drive line low) |
| phase_i | input | 3 | Bus cycle phase: 0 none, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait |
| lock_i | input | 1 | Grant inhibit from a locked instruction |
| float_o | output | 1 | Bus released to an outside master |

## Verification
The assertions assume that each master behaves well. It sends one request pulse and then stays quiet until it is granted. Only the owner sends a release, and only after its grant clock. A master never pulls its line low while the block is driving it. The random masters in the bench are small state machines that obey exactly these rules: idle, waiting for grant, then holding for one to four clocks before releasing. The phase and lock inputs are free random values, so grants meet every phase and every lock timing.

// File: rtl/rg_arb_pkg.sv
package rg_arb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_TW   = 3'd5
  } bus_phase_e;

  typedef enum logic [1:0] {
    OWN_HOME  = 2'd0,
    OWN_GRANT = 2'd1,
    OWN_HELD  = 2'd2
  } own_state_e;

  // phases in which the bus may be handed over
  function automatic logic grant_window(input logic [2:0] ph);
    return (ph == PH_IDLE) || (ph == PH_T1) || (ph == PH_T4);
  endfunction

endpackage

// File: rtl/rg_line_port.sv
module rg_line_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic owner_i,
  input  logic grant_i,
  output logic req_o,
  output logic rel_o,
  output logic drv_o
);

  logic drv_q;
  logic pend_q;
  logic seen_low;

  // own grant clock is masked: line reads low because we pull it
  assign seen_low = ~line_i & ~drv_q;
  assign rel_o    = seen_low & owner_i;
  assign req_o    = pend_q | (seen_low & ~owner_i);
  assign drv_o    = drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      drv_q  <= grant_i;
      pend_q <= req_o & ~grant_i;
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |=> !drv_q);

  assert_owner_no_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_i |-> !pend_q);

endmodule

// File: rtl/rg_prio_pick.sv
module rg_prio_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/rg_xfer_fsm.sv
module rg_xfer_fsm
  import rg_arb_pkg::*;
#(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          any_req_i,
  input  logic [IW-1:0] pick_i,
  input  logic [2:0]    phase_i,
  input  logic          lock_i,
  input  logic [N-1:0]  rel_i,
  output logic [N-1:0]  grant_o,
  output logic [N-1:0]  owner_o,
  output logic          float_o
);

  own_state_e    st_q, st_d;
  logic [IW-1:0] sel_q, sel_d;
  logic          fire;

  assign fire    = (st_q == OWN_HOME) && any_req_i && grant_window(phase_i) && !lock_i;
  assign grant_o = fire ? (N'(1) << pick_i) : '0;
  assign owner_o = (st_q != OWN_HOME) ? (N'(1) << sel_q) : '0;
  assign float_o = (st_q == OWN_HELD);

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    case (st_q)
      OWN_HOME: begin
        if (fire) begin
          st_d  = OWN_GRANT;
          sel_d = pick_i;
        end
      end
      OWN_GRANT: st_d = OWN_HELD;
      OWN_HELD:  if (rel_i[sel_q]) st_d = OWN_HOME;  // home cycle is the dead clock
      default:   st_d = OWN_HOME;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= OWN_HOME;
      sel_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
    end
  end

  assert_hold_owner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (float_o && !rel_i[sel_q]) |=> (float_o && $stable(sel_q)));

  assert_no_fire_away_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != OWN_HOME) |-> (grant_o == '0));

endmodule

// File: rtl/bus_handover_arb.sv
module bus_handover_arb
  import rg_arb_pkg::*;
#(
  parameter int NUM_LINES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] line_drv_o,
  input  logic [2:0]           phase_i,
  input  logic                 lock_i,
  output logic                 float_o
);

  localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] req_vec;
  logic [NUM_LINES-1:0] rel_vec;
  logic [NUM_LINES-1:0] grant_vec;
  logic [NUM_LINES-1:0] owner_vec;
  logic                 any_req;
  logic [IW-1:0]        pick;
  logic                 win_w;

  assign win_w = grant_window(phase_i);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_port
    rg_line_port u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_i[g]),
      .owner_i (owner_vec[g]),
      .grant_i (grant_vec[g]),
      .req_o   (req_vec[g]),
      .rel_o   (rel_vec[g]),
      .drv_o   (line_drv_o[g])
    );
  end

  rg_prio_pick #(.N(NUM_LINES), .IW(IW)) u_pick (
    .req_i (req_vec),
    .any_o (any_req),
    .idx_o (pick)
  );

  rg_xfer_fsm #(.N(NUM_LINES), .IW(IW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_req_i (any_req),
    .pick_i    (pick),
    .phase_i   (phase_i),
    .lock_i    (lock_i),
    .rel_i     (rel_vec),
    .grant_o   (grant_vec),
    .owner_o   (owner_vec),
    .float_o   (float_o)
  );

  assert_one_driver_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_drv_o));

  assert_float_after_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|line_drv_o) |=> float_o);

  assert_grant_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|line_drv_o) |-> $past(win_w));

  assert_no_grant_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (line_drv_o == '0));

  assert_release_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (float_o && (|rel_vec)) |=> !float_o);

  assert_dead_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(float_o) |-> (line_drv_o == '0));

  for (genvar p = 1; p < NUM_LINES; p++) begin : g_prio_chk
    assert_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_drv_o[p] |-> ($past(req_vec[p-1:0]) == '0));
  end

endmodule

// File: tb/sim_bus_handover_arb.sv
`timescale 1ns/100ps
module sim_bus_handover_arb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mst_low = 2'b00;
  logic [2:0] phase = 3'd0;
  logic       lock = 1'b0;
  wire  [1:0] drv;
  wire        flt;
  wire  [1:0] line_w = ~(drv | mst_low);

  bus_handover_arb #(.NUM_LINES(2)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line_w),
    .line_drv_o (drv),
    .phase_i    (phase),
    .lock_i     (lock),
    .float_o    (flt)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  // reference model state
  int         m_st = 0;
  int         m_sel = 0;
  logic [1:0] m_pend = 2'b00;
  logic [1:0] m_drv = 2'b00;
  logic       m_flt = 1'b0;

  int ms[2];
  int mcnt[2];

  function automatic bit win(input logic [2:0] p);
    return (p == 3'd0) || (p == 3'd1) || (p == 3'd4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [1:0] lo;
    logic [1:0] nd;
    logic [1:0] req;
    lo = mst_low & ~m_drv;
    nd = 2'b00;
    case (m_st)
      0: begin
        req = m_pend | lo;
        if (req != 2'b00 && win(phase) && !lock) begin
          m_sel  = req[0] ? 0 : 1;
          nd     = 2'b01 << m_sel;
          m_pend = req & ~nd;
          m_st   = 1;
        end else begin
          m_pend = req;
        end
      end
      1: begin
        m_pend = m_pend | (lo & ~(2'b01 << m_sel));
        m_st   = 2;
      end
      default: begin
        m_pend = m_pend | (lo & ~(2'b01 << m_sel));
        if (lo[m_sel]) m_st = 0;
      end
    endcase
    m_drv = nd;
    m_flt = (m_st == 2);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    #1;
    mst_low = 2'b00;
    if (cmp_on) begin
      chk("R10 model drive", 32'(drv), 32'(m_drv));
      chk("R4 model float", 32'(flt), 32'(m_flt));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset drive", 32'(drv), 0);
    chk("R1 reset float", 32'(flt), 0);
    rst_n = 1'b1;
    step();
    chk("R1 first cycle drive", 32'(drv), 0);

    // R9: quiet lines
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R9 idle drive", 32'(drv), 0);
      chk("R9 idle float", 32'(flt), 0);
    end

    // R2 R4 R5: request on line 1 during T4
    phase = 3'd4; mst_low[1] = 1'b1;
    step();
    chk("R2 grant line1", 32'(drv), 2);
    chk("R4 no float in grant clock", 32'(flt), 0);
    phase = 3'd0;
    step();
    chk("R2 one clock wide", 32'(drv), 0);
    chk("R4 float rises", 32'(flt), 1);
    step(); step();
    chk("R4 float held", 32'(flt), 1);
    mst_low[1] = 1'b1;
    step();
    chk("R5 release", 32'(flt), 0);
    chk("R6 dead after release", 32'(drv), 0);
    step();

    // R3: wrong phases hold the request
    phase = 3'd2; mst_low[0] = 1'b1;
    step();
    chk("R3 no grant T2", 32'(drv), 0);
    phase = 3'd3; step();
    chk("R3 no grant T3", 32'(drv), 0);
    phase = 3'd5; step();
    chk("R3 no grant wait", 32'(drv), 0);
    phase = 3'd1; step();
    chk("R3 grant at T1", 32'(drv), 1);
    phase = 3'd0; step();
    chk("R4 float after T1 grant", 32'(flt), 1);
    mst_low[0] = 1'b1; step();
    chk("R5 release line0", 32'(flt), 0);
    step();

    // R7 R6: both request together
    mst_low = 2'b11;
    step();
    chk("R7 line0 wins", 32'(drv), 1);
    step(); step();
    mst_low[0] = 1'b1; step();
    chk("R5 release line0 prio", 32'(flt), 0);
    chk("R6 dead clock", 32'(drv), 0);
    step();
    chk("R7 line1 served after", 32'(drv), 2);
    step();
    chk("R4 float for line1", 32'(flt), 1);
    mst_low[1] = 1'b1; step();
    chk("R5 release line1", 32'(flt), 0);
    step();

    // R11: other line asks while owned
    mst_low[0] = 1'b1; step();
    chk("R2 grant line0", 32'(drv), 1);
    step();
    mst_low[1] = 1'b1; step();
    chk("R11 held while owned", 32'(drv), 0);
    chk("R11 still floating", 32'(flt), 1);
    step();
    mst_low[0] = 1'b1; step();
    chk("R11 release", 32'(flt), 0);
    chk("R6 dead before pending", 32'(drv), 0);
    step();
    chk("R11 pending served", 32'(drv), 2);
    step();
    mst_low[1] = 1'b1; step();
    chk("R5 release after pending", 32'(flt), 0);
    step();

    // R8: lock inhibits grant, keeps request
    lock = 1'b1; mst_low[0] = 1'b1;
    step();
    chk("R8 no grant locked", 32'(drv), 0);
    step(); step(); step();
    chk("R8 still none", 32'(drv), 0);
    chk("R8 no float", 32'(flt), 0);
    lock = 1'b0; step();
    chk("R8 kept request granted", 32'(drv), 1);
    step();
    mst_low[0] = 1'b1; step();
    chk("R5 release after lock", 32'(flt), 0);
    step();

    // random masters checked against the model
    cmp_on = 1;
    ms[0] = 0; ms[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
    for (int c = 0; c < 3000; c++) begin
      phase = 3'($urandom_range(0, 5));
      lock  = ($urandom_range(0, 7) == 0);
      for (int i = 0; i < 2; i++) begin
        case (ms[i])
          0: if ($urandom_range(0, 5) == 0) begin
               mst_low[i] = 1'b1;
               ms[i] = 1;
             end
          1: if (drv[i]) begin
               ms[i] = 2;
               mcnt[i] = $urandom_range(1, 4);
             end
          default: begin
            mcnt[i]--;
            if (mcnt[i] == 0) begin
              mst_low[i] = 1'b1;
              ms[i] = 0;
            end
          end
        endcase
      end
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule